// File: doc/BRIEF.md
# Dual-Placement Byte Cache with Least-Frequently-Used Eviction

This block is a small read-only cache for bytes. It sits between a requester and a byte-wide synchronous memory of 256 locations. The cache holds eight lines, and each line holds one aligned four-byte block. A static placement selector decides how blocks map to lines. In direct placement, a block can live in exactly one line, chosen by address bits. In associative placement, a block can live in any line.

The requester offers an address with a valid/ready handshake. Each accepted request produces one response pulse carrying the following:
- the addressed byte;
- a hit flag;
- an eviction flag;
- the line that served the request;
- that line's hit counter after the access.

On a miss, the whole block is fetched one byte per cycle, and the line is then written in one step. Each line keeps a saturating hit counter. In associative placement, that counter is the key for choosing which line to evict.

Top module: `modal_byte_cache`

## Requirements
- R1: After reset, no line is present: `req_ready` is high, `rsp_valid` and `mem_rd_en` are low, and the first access to any address is a miss without eviction.
- R2: In direct placement (`mode_fa`=0), address bits [1:0] select the byte, bits [4:2] select the line, and bits [7:5] form the tag. A present line with an equal tag is a hit. A present line with another tag is a miss with `rsp_evict`=1. An absent line is a miss with `rsp_evict`=0.
- R3: In associative placement (`mode_fa`=1), the block number is bits [7:2], and a hit may come from any present line holding that block. On a miss, the lowest-numbered absent line is filled and `rsp_evict` stays 0.
- R4: In associative placement, a miss with all eight lines present evicts the line with the smallest hit counter. Ties go to the lowest line number, and `rsp_evict` is 1.
- R5: A filled line reports a counter of 1. Each hit adds one and reports the new value. The counter saturates at 255.
- R6: A miss performs exactly four memory reads on consecutive cycles, at addresses {block, 0} through {block, 3} in ascending order. A hit performs no memory read, and no read occurs while `req_ready` is high.
- R7: `rsp_data` equals the memory byte at the requested address, on both hits and misses.
- R8: `req_ready` is low only during a fill. A hit responds in the first cycle after acceptance. A miss responds in the sixth cycle after acceptance.
- R9: Placement is taken from `mode_fa` at acceptance. Changing `mode_fa` while a fill is in progress does not alter that request's line, flags or data.
- R10: Each accepted request yields exactly one single-cycle `rsp_valid` pulse, and `rsp_hit` and `rsp_evict` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fa | input | 1 | Placement select: 0 direct, 1 associative |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 8 | Byte address of the request |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 8 | Requested byte |
| rsp_hit | output | 1 | Request hit |
| rsp_evict | output | 1 | Miss replaced a present line |
| rsp_line | output | 3 | Line that served the request |
| rsp_count | output | 8 | Hit counter of that line after the access |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 8 | Memory read address |
| mem_rdata | input | 8 | Memory data, valid the cycle after the read |

## Verification
A hit must raise `rsp_valid` in the first cycle after the accepting edge. A miss must raise it in the sixth cycle: four read cycles, one cycle for the last byte to return, and one cycle for the line write and response register.

After each acceptance, the bench counts falling edges until `rsp_valid` appears and compares that count with the expected latency. All response fields are sampled at that same falling edge. The read strobes and addresses seen between acceptance and response are compared with the block the request must load.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;

  // Counter increment that sticks at its maximum value.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int w);
    logic [31:0] top_v;
    top_v = (32'd1 << w) - 32'd1;
    return (v >= top_v) ? top_v : v + 32'd1;
  endfunction

  // Block number: address with the byte offset removed.
  function automatic logic [31:0] block_of(input logic [31:0] a, input int off_w);
    return a >> off_w;
  endfunction

  // Direct-placement line: low bits of the block number.
  function automatic logic [31:0] dm_slot(input logic [31:0] a, input int off_w, input int idx_w);
    return (a >> off_w) & ((32'd1 << idx_w) - 32'd1);
  endfunction

endpackage

// File: rtl/mbc_lines.sv
module mbc_lines #(
  parameter int LINES     = 8,
  parameter int BLK_W     = 6,
  parameter int CNT_W     = 8,
  parameter int LINE_BITS = 32,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [BLK_W-1:0]                  wr_blk,
  input  logic [LINE_BITS-1:0]              wr_data,
  input  logic                              bump_en,
  input  logic [IDX_W-1:0]                  bump_idx,
  output logic [LINES-1:0]                  valid_o,
  output logic [LINES-1:0][BLK_W-1:0]       blk_o,
  output logic [LINES-1:0][CNT_W-1:0]       cnt_o,
  output logic [LINES-1:0][LINE_BITS-1:0]   data_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                 sel_wr;
    logic                 sel_bump;
    assign sel_wr   = wr_en && (wr_idx == IDX_W'(g));
    assign sel_bump = bump_en && (bump_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        blk_o[g]   <= '0;
        cnt_o[g]   <= '0;
        data_o[g]  <= '0;
      end else if (sel_wr) begin
        valid_o[g] <= 1'b1;
        blk_o[g]   <= wr_blk;
        cnt_o[g]   <= CNT_W'(1);
        data_o[g]  <= wr_data;
      end else if (sel_bump) begin
        cnt_o[g]   <= CNT_W'(mbc_pkg::sat_inc(32'(cnt_o[g]), CNT_W));
      end
    end
  end

endmodule

// File: rtl/mbc_lookup.sv
module mbc_lookup #(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic                        mode_fa,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LINES-1:0]            valid,
  input  logic [LINES-1:0][BLK_W-1:0] blk,
  input  logic [LINES-1:0][CNT_W-1:0] cnt,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx,
  output logic [IDX_W-1:0]            victim_idx,
  output logic                        victim_evict
);

  logic [BLK_W-1:0] req_blk;
  logic [IDX_W-1:0] dm_idx;
  logic [LINES-1:0] match;

  assign req_blk = BLK_W'(mbc_pkg::block_of(32'(addr), OFF_W));
  assign dm_idx  = IDX_W'(mbc_pkg::dm_slot(32'(addr), OFF_W, IDX_W));

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match[g] = valid[g] && (blk[g] == req_blk);
  end

  logic             fa_hit;
  logic [IDX_W-1:0] fa_hit_idx;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] lfu_idx;
  logic [CNT_W-1:0] lfu_cnt;

  // Priority scans: descending overwrite leaves the lowest index.
  always_comb begin
    fa_hit     = 1'b0;
    fa_hit_idx = '0;
    free_any   = 1'b0;
    free_idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i]) begin
        fa_hit     = 1'b1;
        fa_hit_idx = IDX_W'(i);
      end
      if (!valid[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Minimum counter; strict compare keeps the lowest index on ties.
  always_comb begin
    lfu_idx = '0;
    lfu_cnt = cnt[0];
    for (int i = 1; i < LINES; i++) begin
      if (cnt[i] < lfu_cnt) begin
        lfu_cnt = cnt[i];
        lfu_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (mode_fa) begin
      hit          = fa_hit;
      hit_idx      = fa_hit_idx;
      victim_idx   = free_any ? free_idx : lfu_idx;
      victim_evict = !free_any;
    end else begin
      hit          = match[dm_idx];
      hit_idx      = dm_idx;
      victim_idx   = dm_idx;
      victim_evict = valid[dm_idx];
    end
  end

endmodule

// File: rtl/mbc_fill.sv
module mbc_fill #(
  parameter int ADDR_W      = 8,
  parameter int BLOCK_BYTES = 4,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - OFF_W,
  localparam int BW         = mbc_pkg::BYTE_W,
  localparam int LINE_BITS  = BLOCK_BYTES * BW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BLK_W-1:0]     start_blk,
  input  logic [BW-1:0]        mem_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [LINE_BITS-1:0] line_data
);

  localparam logic [OFF_W:0] LAST = (OFF_W + 1)'(BLOCK_BYTES);

  mbc_pkg::fill_state_e              state;
  logic [OFF_W:0]                    beat;
  logic [BLK_W-1:0]                  blk_q;
  logic [BLOCK_BYTES-1:0][BW-1:0]    bytes_q;

  assign busy      = (state == mbc_pkg::FS_FILL);
  assign mem_rd_en = busy && (beat < LAST);
  assign mem_addr  = {blk_q, beat[OFF_W-1:0]};
  assign done      = busy && (beat == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= mbc_pkg::FS_IDLE;
      beat    <= '0;
      blk_q   <= '0;
      bytes_q <= '0;
    end else begin
      case (state)
        mbc_pkg::FS_IDLE: begin
          if (start) begin
            state <= mbc_pkg::FS_FILL;
            beat  <= '0;
            blk_q <= start_blk;
          end
        end
        default: begin
          if (beat != '0) begin
            bytes_q[OFF_W'(beat - 1'b1)] <= mem_rdata;
          end
          if (done) begin
            state <= mbc_pkg::FS_IDLE;
          end else begin
            beat <= beat + 1'b1;
          end
        end
      endcase
    end
  end

  // The last byte is taken straight from memory in the closing cycle.
  for (genvar k = 0; k < BLOCK_BYTES; k++) begin : g_merge
    if (k == BLOCK_BYTES - 1) begin : g_tail
      assign line_data[k*BW +: BW] = mem_rdata;
    end else begin : g_body
      assign line_data[k*BW +: BW] = bytes_q[k];
    end
  end

endmodule

// File: rtl/modal_byte_cache.sv
module modal_byte_cache #(
  parameter int ADDR_W      = 8,
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 4,
  parameter int CNT_W       = 8,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(LINES),
  localparam int BLK_W      = ADDR_W - OFF_W,
  localparam int BW         = mbc_pkg::BYTE_W,
  localparam int LINE_BITS  = BLOCK_BYTES * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_fa,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [BW-1:0]     rsp_data,
  output logic              rsp_hit,
  output logic              rsp_evict,
  output logic [IDX_W-1:0]  rsp_line,
  output logic [CNT_W-1:0]  rsp_count,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BW-1:0]     mem_rdata
);

  logic [LINES-1:0]                line_valid;
  logic [LINES-1:0][BLK_W-1:0]     line_blk;
  logic [LINES-1:0][CNT_W-1:0]     line_cnt;
  logic [LINES-1:0][LINE_BITS-1:0] line_data;

  // Named internal events.
  logic                 accept;
  logic                 lookup_hit;
  logic [IDX_W-1:0]     hit_idx;
  logic [IDX_W-1:0]     victim_idx;
  logic                 victim_evict;
  logic                 fill_busy;
  logic                 fill_done;
  logic [LINE_BITS-1:0] fill_line;
  logic                 miss_start;
  logic                 hit_take;

  logic [BLK_W-1:0]     req_blk;
  logic [OFF_W-1:0]     req_off;
  logic [BLK_W-1:0]     pend_blk_q;
  logic [OFF_W-1:0]     pend_off_q;
  logic [IDX_W-1:0]     pend_idx_q;
  logic                 pend_evict_q;

  assign req_ready  = !fill_busy;
  assign accept     = req_valid && req_ready;
  assign hit_take   = accept && lookup_hit;
  assign miss_start = accept && !lookup_hit;
  assign req_blk    = BLK_W'(mbc_pkg::block_of(32'(req_addr), OFF_W));
  assign req_off    = req_addr[OFF_W-1:0];

  mbc_lookup #(
    .ADDR_W (ADDR_W),
    .LINES  (LINES),
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W)
  ) u_lookup (
    .mode_fa      (mode_fa),
    .addr         (req_addr),
    .valid        (line_valid),
    .blk          (line_blk),
    .cnt          (line_cnt),
    .hit          (lookup_hit),
    .hit_idx      (hit_idx),
    .victim_idx   (victim_idx),
    .victim_evict (victim_evict)
  );

  mbc_fill #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
  ) u_fill (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (miss_start),
    .start_blk (req_blk),
    .mem_rdata (mem_rdata),
    .busy      (fill_busy),
    .done      (fill_done),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .line_data (fill_line)
  );

  mbc_lines #(
    .LINES     (LINES),
    .BLK_W     (BLK_W),
    .CNT_W     (CNT_W),
    .LINE_BITS (LINE_BITS)
  ) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fill_done),
    .wr_idx   (pend_idx_q),
    .wr_blk   (pend_blk_q),
    .wr_data  (fill_line),
    .bump_en  (hit_take),
    .bump_idx (hit_idx),
    .valid_o  (line_valid),
    .blk_o    (line_blk),
    .cnt_o    (line_cnt),
    .data_o   (line_data)
  );

  // Placement and victim are fixed at acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_blk_q   <= '0;
      pend_off_q   <= '0;
      pend_idx_q   <= '0;
      pend_evict_q <= 1'b0;
    end else if (miss_start) begin
      pend_blk_q   <= req_blk;
      pend_off_q   <= req_off;
      pend_idx_q   <= victim_idx;
      pend_evict_q <= victim_evict;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_line  <= '0;
      rsp_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (hit_take) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_evict <= 1'b0;
        rsp_line  <= hit_idx;
        rsp_count <= CNT_W'(mbc_pkg::sat_inc(32'(line_cnt[hit_idx]), CNT_W));
        rsp_data  <= line_data[hit_idx][BW*req_off +: BW];
      end else if (fill_done) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_evict <= pend_evict_q;
        rsp_line  <= pend_idx_q;
        rsp_count <= CNT_W'(1);
        rsp_data  <= fill_line[BW*pend_off_q +: BW];
      end
    end
  end

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept,
  input logic              lookup_hit,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_evict,
  input logic [CNT_W-1:0]  rsp_count,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr
);

  a_r8_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lookup_hit) |=> (rsp_valid && rsp_hit));

  a_r6_miss_starts_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lookup_hit) |=> (mem_rd_en && mem_addr[OFF_W-1:0] == '0 && !req_ready));

  a_r6_reads_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_addr[OFF_W-1:0] != {OFF_W{1'b1}}) |=>
      (mem_rd_en && mem_addr == $past(mem_addr) + 1'b1));

  a_r6_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_evict));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |=> !rsp_valid);

  a_r5_fill_count_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_count == CNT_W'(1)));

  a_r5_hit_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_count >= CNT_W'(2)));

endmodule

bind modal_byte_cache mbc_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .accept     (accept),
  .lookup_hit (lookup_hit),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_evict  (rsp_evict),
  .rsp_count  (rsp_count),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr)
);

// File: tb/modal_byte_cache_tb.sv
`timescale 1ns/1ps
module modal_byte_cache_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_fa = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_addr = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_hit;
  logic       rsp_evict;
  logic [2:0] rsp_line;
  logic [7:0] rsp_count;
  logic       mem_rd_en;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modal_byte_cache u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_fa   (mode_fa),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_hit   (rsp_hit),
    .rsp_evict (rsp_evict),
    .rsp_line  (rsp_line),
    .rsp_count (rsp_count),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] memfn(input logic [7:0] a);
    return (a * 8'd29 + 8'd7) ^ (a >> 3);
  endfunction

  // Memory model and read monitor.
  int         rd_total = 0;
  int         rd_start = 0;
  int         addr_bad = 0;
  logic [7:0] exp_base = '0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      if (mem_addr != exp_base + 8'(rd_total - rd_start)) addr_bad <= addr_bad + 1;
      rd_total  <= rd_total + 1;
      mem_rdata <= memfn(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model state.
  bit       mv[8];
  bit [5:0] mb[8];
  int       mc[8];

  task automatic model(input logic [7:0] a, input bit fa, output bit eh, output bit er,
                       output int el, output int ec);
    bit [5:0] blk;
    int idx;
    bit found;
    blk = a[7:2];
    eh = 0; er = 0; idx = 0;
    if (!fa) begin
      idx = int'(a[4:2]);
      if (mv[idx] && mb[idx] == blk) eh = 1;
      else er = mv[idx];
    end else begin
      found = 0;
      for (int i = 0; i < 8; i++)
        if (!found && mv[i] && mb[i] == blk) begin found = 1; idx = i; end
      if (found) eh = 1;
      else begin
        for (int i = 7; i >= 0; i--) if (!mv[i]) begin found = 1; idx = i; end
        if (!found) begin
          er = 1; idx = 0;
          for (int i = 1; i < 8; i++) if (mc[i] < mc[idx]) idx = i;
        end
      end
    end
    if (eh) begin
      if (mc[idx] < 255) mc[idx]++;
    end else begin
      mv[idx] = 1; mb[idx] = blk; mc[idx] = 1;
    end
    el = idx;
    ec = mc[idx];
  endtask

  task automatic do_reset(input bit fa);
    @(negedge clk);
    rst_n = 0; mode_fa = fa; req_valid = 0;
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mb[i] = 0; mc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", mem_rd_en, 0);
  endtask

  // One request; optionally flips the mode during the wait (R9).
  task automatic do_req(input logic [7:0] a, input bit flip);
    bit eh, er; int el, ec; int n; int reads;
    model(a, mode_fa, eh, er, el, ec);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready when idle", req_ready, 1);
    req_valid = 1; req_addr = a;
    rd_start  = rd_total;
    exp_base  = {a[7:2], 2'b00};
    addr_bad  = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (flip) mode_fa = ~mode_fa;
    n = 1;
    if (!eh) chk(req_ready == 1'b0, "R8", "ready low in fill", req_ready, 0);
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    reads = rd_total - rd_start;
    chk(n == (eh ? 1 : 6), "R8", "response latency", n, eh ? 1 : 6);
    chk(rsp_hit == eh, "R2/R3 hit", "rsp_hit", rsp_hit, eh);
    chk(rsp_evict == er, "R2/R4 evict", "rsp_evict", rsp_evict, er);
    chk(int'(rsp_line) == el, "R3/R4 line", "rsp_line", rsp_line, el);
    chk(int'(rsp_count) == ec, "R5", "rsp_count", rsp_count, ec);
    chk(rsp_data == memfn(a), "R7", "rsp_data", rsp_data, memfn(a));
    chk(reads == (eh ? 0 : 4), "R6", "read count", reads, eh ? 0 : 4);
    chk(addr_bad == 0, "R6", "read address order", addr_bad, 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "single pulse", rsp_valid, 0);
    if (flip) mode_fa = ~mode_fa;
  endtask

  initial begin
    logic [7:0] lf;
    // Direct placement, worked cases then full sweep.
    do_reset(1'b0);
    do_req(8'h00, 0);   // R1: first access misses, no eviction
    do_req(8'h01, 0);   // R2: hit, counter 2
    do_req(8'h10, 0);   // R2: line 4
    do_req(8'h20, 0);   // R2: line 0, tag 1, evicts
    for (int a = 0; a < 256; a++) do_req(8'(a), 0);
    lf = 8'h5A;
    for (int k = 0; k < 200; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_req(lf, 0);
    end

    // Associative placement: fill, shape counters, LFU with tie.
    do_reset(1'b1);
    for (int b = 0; b < 8; b++) do_req(8'(b * 4), 0);          // R3
    for (int b = 0; b < 8; b++)
      if (b != 3 && b != 5) do_req(8'(b * 4 + 1), 0);
    do_req(8'h20, 0);   // R4: evicts line 3 (tie with 5)
    do_req(8'h24, 0);   // R4: line 3 again (count 1, lowest)
    do_req(8'h28, 0);
    lf = 8'h33;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      do_req(8'(lf % 8'd48), 0);
    end

    // Saturation of the hit counter.
    do_reset(1'b1);
    for (int k = 0; k < 260; k++) do_req(8'h40 + 8'(k % 4), 0);   // R5

    // Mode change during a fill.
    do_reset(1'b1);
    do_req(8'h10, 1);   // R9: stays on line 0
    do_req(8'h12, 0);   // R9: hit on line 0

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule